// File: doc/BRIEF.md
# Logic Cell with Local Context Sequencer

This block is one configurable logic cell of a fine-grained array, together with a local store for its next configuration and a small sequencer that loads that configuration into the cell. The cell computes through a 4-input lookup table. It has carry logic for arithmetic, an output flip-flop with a configurable set/reset value, a choice between registered and combinational output, and a mode in which the lookup table acts as a 16x1 RAM. Its 20 configuration bits enter through a serial configuration path, one bit per clock.

The next configuration is shifted into the local store in the background while the cell keeps computing, over a scan chain that can be daisy-chained from cell to cell. A reconfiguration request starts a local counter. The counter walks through the stored bits and feeds them one per clock into the cell's serial path. The cell keeps its old configuration until the last bit has arrived, then switches in one step and pulses a done flag. Every cell in an array runs its own sequencer at the same time, so the whole array switches in 20 cycles whatever its size.

Top module: `lcell_ctx_top`

## Requirements
- R1: After a synchronous active-high reset, busy and done are 0, the context store, the active configuration and the output flip-flop are all 0, and so cell_out is 0 for any input and scan_out is 0.
- R2: While scan_en is 1 and no reconfiguration is running, each clock shifts the store by one: scan_in enters bit 0, and bit 19 of the store is always visible on scan_out. After 20 shifts, the first bit shifted in sits at bit 19.
- R3: A reconf_req seen while idle sets busy on the next clock. busy stays high for exactly 20 cycles. In the cycle after busy falls, done is high for exactly one cycle.
- R4: While busy is high, the cell keeps computing with its previous configuration, and cell_out follows that configuration.
- R5: In the cycle where done is high, the active configuration equals the stored context. The layout is: bits 15:0 are the truth table, indexed by the LUT address; bit 16 is the set/reset value; bit 17 selects the registered output (1) or the combinational output (0); bit 18 selects carry; bit 19 enables RAM mode.
- R6: While busy is high, a further reconf_req and any scan_en are ignored. The run keeps its length, and the store keeps its content.
- R7: With bit 17 at 0, cell_out equals the truth-table bit at the LUT address in the same cycle.
- R8: With bit 17 at 1, cell_out shows the flip-flop. The flip-flop loads the truth-table output on a clock with cell_ce at 1 and holds its value when cell_ce is 0.
- R9: cell_sr at 1 forces the flip-flop to the set/reset value on the next clock, with priority over cell_ce.
- R10: With bit 18 at 1, carry_in replaces cell_in[3] as the top LUT address bit. carry_out is always the majority of cell_in[0], cell_in[1] and carry_in.
- R11: In RAM mode, ram_we writes ram_din into the truth-table bit at the LUT address on the next clock. Outside RAM mode, ram_we has no effect. A completed reconfiguration replaces anything that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Shift the context store by one bit |
| scan_in | input | 1 | Serial context data in |
| scan_out | output | 1 | Top bit of the context store, for chaining |
| reconf_req | input | 1 | Start loading the stored context |
| reconf_busy | output | 1 | Sequencer is feeding bits |
| reconf_done | output | 1 | One-cycle pulse: new configuration active |
| cell_in | input | 4 | LUT inputs |
| carry_in | input | 1 | Carry from neighbour cell |
| carry_out | output | 1 | Carry to neighbour cell |
| cell_ce | input | 1 | Output flip-flop clock enable |
| cell_sr | input | 1 | Synchronous force of flip-flop to set/reset value |
| ram_we | input | 1 | RAM-mode write enable |
| ram_din | input | 1 | RAM-mode write data |
| cell_out | output | 1 | Cell output (registered or combinational) |

## Verification
A sequencer counter that slips by even one count shows up at reconf_busy and reconf_done: the done pulse lands a cycle early or late against the fixed 20-cycle window, and this is visible on the first reconfiguration. A mistake in bit order, or a store corrupted during a run, shows up at cell_out as a wrong truth table or wrong mode in the very cycle done rises. A scan-out readback that recirculates the store reveals the stored bits one per cycle. A premature switch to the new configuration shows up as a wrong cell_out inside the busy window, before done.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int CTRL_BITS = 4;
  // Control bit offsets above the truth table
  localparam int CTRL_SRV  = 0;
  localparam int CTRL_OREG = 1;
  localparam int CTRL_CSEL = 2;
  localparam int CTRL_RAM  = 3;

  function automatic int cfg_width(input int lut_k);
    return (1 << lut_k) + CTRL_BITS;
  endfunction
endpackage

// File: rtl/lcell_ctx_store.sv
module lcell_ctx_store #(
  parameter int CFG_BITS = 20,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic             hold,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             scan_out,
  output logic             sel_bit
);
  logic [CFG_BITS-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (scan_en && !hold) begin
      store_q <= {store_q[CFG_BITS-2:0], scan_in};
    end
  end

  assign scan_out = store_q[CFG_BITS-1];
  assign sel_bit  = store_q[bit_idx];
endmodule

// File: rtl/lcell_seq.sv
module lcell_seq #(
  parameter int CFG_BITS = 20,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  output logic             busy,
  output logic             last,
  output logic             done,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(CFG_BITS - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == LAST_CNT) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign last    = busy_q && (cnt_q == LAST_CNT);
  // Highest stored bit leaves first so it lands at the top of the chain
  assign bit_idx = LAST_CNT - cnt_q;
endmodule

// File: rtl/lcell_core.sv
module lcell_core
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             load,
  input  logic             ser_bit,
  input  logic [LUT_K-1:0] cell_in,
  input  logic             carry_in,
  input  logic             cell_ce,
  input  logic             cell_sr,
  input  logic             ram_we,
  input  logic             ram_din,
  output logic             cell_out,
  output logic             carry_out
);
  localparam int LUT_BITS = 1 << LUT_K;
  localparam int CFG_BITS = LUT_BITS + CTRL_BITS;

  logic [CFG_BITS-1:0] chain_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic [CFG_BITS-1:0] chain_nxt;
  logic [LUT_K-1:0]    lut_addr;
  logic                lut_out;
  logic                q_reg;
  logic                c_srv, c_oreg, c_csel, c_ram;

  assign c_srv  = cfg_q[LUT_BITS + CTRL_SRV];
  assign c_oreg = cfg_q[LUT_BITS + CTRL_OREG];
  assign c_csel = cfg_q[LUT_BITS + CTRL_CSEL];
  assign c_ram  = cfg_q[LUT_BITS + CTRL_RAM];

  assign chain_nxt = {chain_q[CFG_BITS-2:0], ser_bit};

  // Serial configuration path; active set swaps only on the final bit
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= chain_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= chain_nxt;
    end else if (c_ram && ram_we) begin
      cfg_q[lut_addr] <= ram_din;
    end
  end

  assign lut_addr  = {(c_csel ? carry_in : cell_in[LUT_K-1]), cell_in[LUT_K-2:0]};
  assign lut_out   = cfg_q[lut_addr];
  assign carry_out = (cell_in[0] & cell_in[1]) | (carry_in & (cell_in[0] ^ cell_in[1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg <= 1'b0;
    end else if (cell_sr) begin
      q_reg <= c_srv;
    end else if (cell_ce) begin
      q_reg <= lut_out;
    end
  end

  assign cell_out = c_oreg ? q_reg : lut_out;
endmodule

// File: rtl/lcell_ctx_top.sv
module lcell_ctx_top
  import lcell_pkg::*;
#(
  parameter int LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             reconf_req,
  output logic             reconf_busy,
  output logic             reconf_done,
  input  logic [LUT_K-1:0] cell_in,
  input  logic             carry_in,
  output logic             carry_out,
  input  logic             cell_ce,
  input  logic             cell_sr,
  input  logic             ram_we,
  input  logic             ram_din,
  output logic             cell_out
);
  localparam int CFG_BITS = cfg_width(LUT_K);
  localparam int IDX_W    = $clog2(CFG_BITS);

  logic             busy, last, done, sel_bit;
  logic [IDX_W-1:0] bit_idx;

  lcell_seq #(.CFG_BITS(CFG_BITS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .req(reconf_req),
    .busy(busy), .last(last), .done(done), .bit_idx(bit_idx)
  );

  lcell_ctx_store #(.CFG_BITS(CFG_BITS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .hold(busy), .bit_idx(bit_idx), .scan_out(scan_out), .sel_bit(sel_bit)
  );

  lcell_core #(.LUT_K(LUT_K)) u_core (
    .clk(clk), .rst(rst), .shift_en(busy), .load(last), .ser_bit(sel_bit),
    .cell_in(cell_in), .carry_in(carry_in), .cell_ce(cell_ce), .cell_sr(cell_sr),
    .ram_we(ram_we), .ram_din(ram_din), .cell_out(cell_out), .carry_out(carry_out)
  );

  assign reconf_busy = busy;
  assign reconf_done = done;
endmodule

// File: rtl/lcell_ctx_chk.sv
module lcell_ctx_chk #(
  parameter int CFG_BITS = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                reconf_req,
  input logic                busy,
  input logic                done,
  input logic                cell_sr,
  input logic                srv,
  input logic                q_reg,
  input logic [CFG_BITS-1:0] store_q,
  input logic [CFG_BITS-1:0] cfg_q
);
  localparam int CTRL_LO = CFG_BITS - 4;

  p_req_start_r3: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && !busy) |=> busy);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_q[CFG_BITS-1:CTRL_LO]));
  p_load_match_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (cfg_q == store_q));
  p_store_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(store_q));
  p_sr_force_r9: assert property (@(posedge clk) disable iff (rst)
    cell_sr |=> (q_reg == $past(srv)));
endmodule

bind lcell_ctx_top lcell_ctx_chk #(.CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rst(rst), .reconf_req(reconf_req), .busy(reconf_busy),
  .done(reconf_done), .cell_sr(cell_sr),
  .srv(u_core.c_srv), .q_reg(u_core.q_reg),
  .store_q(u_store.store_q), .cfg_q(u_core.cfg_q)
);

// File: tb/lcell_ctx_top_tb_top.sv
module lcell_ctx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_en = 0, scan_in = 0, reconf_req = 0;
  logic       carry_in = 0, cell_ce = 0, cell_sr = 0, ram_we = 0, ram_din = 0;
  logic [3:0] cell_in = '0;
  logic       scan_out, reconf_busy, reconf_done, carry_out, cell_out;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lcell_ctx_top dut_i (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .reconf_req(reconf_req), .reconf_busy(reconf_busy), .reconf_done(reconf_done),
    .cell_in(cell_in), .carry_in(carry_in), .carry_out(carry_out),
    .cell_ce(cell_ce), .cell_sr(cell_sr), .ram_we(ram_we), .ram_din(ram_din),
    .cell_out(cell_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // R2: MSB first, so it ends at store bit 19
  task automatic load_ctx(input logic [19:0] c);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk); scan_en = 1; scan_in = c[i];
    end
    @(negedge clk); scan_en = 0;
  endtask

  // R2/R6: read the store through scan_out while recirculating it
  task automatic read_ctx(input logic [19:0] c, input string tag);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      chk(tag, scan_out, c[i]);
      scan_en = 1; scan_in = scan_out;
    end
    @(negedge clk); scan_en = 0;
  endtask

  // R3/R4/R6: full run with stray request and scan pulses inside
  task automatic do_reconf(input logic old_exp);
    @(negedge clk); reconf_req = 1;
    @(negedge clk); reconf_req = 0;
    chk("R3 busy rise", reconf_busy, 1);
    chk("R4 old cfg", cell_out, old_exp);
    for (int i = 1; i < 20; i++) begin
      if (i == 3) begin scan_en = 1; scan_in = 1; end
      if (i == 7) scan_en = 0;
      if (i == 9) reconf_req = 1;
      if (i == 10) reconf_req = 0;
      @(negedge clk);
      chk("R3 R6 busy held", {reconf_busy, reconf_done}, 2'b10);
      chk("R4 old cfg", cell_out, old_exp);
    end
    @(negedge clk);
    chk("R3 done pulse", {reconf_busy, reconf_done}, 2'b01);
    @(negedge clk);
    chk("R3 done one cycle", {reconf_busy, reconf_done}, 2'b00);
  endtask

  task automatic t_reset;
    cell_in = 4'hF;
    @(negedge clk);
    chk("R1 busy/done", {reconf_busy, reconf_done}, 2'b00);
    chk("R1 out", cell_out, 0);
    chk("R1 scan_out", scan_out, 0);
  endtask

  task automatic t_and_comb;
    logic [19:0] c = {4'b0000, 16'h8000};
    load_ctx(c);
    read_ctx(c, "R2 readback");
    cell_in = 4'hF;
    do_reconf(1'b0);
    chk("R5 R7 and F", cell_out, 1);
    cell_in = 4'hE; @(negedge clk);
    chk("R7 and E", cell_out, 0);
    read_ctx(c, "R6 store kept");
  endtask

  task automatic t_reg;
    logic [19:0] c = 20'h36666;
    load_ctx(c);
    cell_in = 4'hF;
    do_reconf(1'b1);
    chk("R8 q from reset", cell_out, 0);
    cell_ce = 1; cell_in = 4'h1; @(negedge clk);
    chk("R8 load 1", cell_out, 1);
    cell_ce = 0; cell_in = 4'h0; @(negedge clk);
    chk("R8 hold", cell_out, 1);
    cell_ce = 1; cell_in = 4'h3; @(negedge clk);
    chk("R8 load 0", cell_out, 0);
    cell_sr = 1; cell_in = 4'h0; @(negedge clk);
    chk("R9 sr over ce", cell_out, 1);
    cell_sr = 0; @(negedge clk);
    chk("R9 release", cell_out, 0);
    cell_ce = 0;
  endtask

  task automatic t_carry;
    logic [19:0] c;
    logic [15:0] t;
    for (int a = 0; a < 16; a++) t[a] = a[0] ^ a[1] ^ a[3];
    c = {4'b0100, t};
    load_ctx(c);
    cell_in = 4'h0;
    do_reconf(1'b0);
    for (int k = 0; k < 8; k++) begin
      logic ci = k[2];
      logic b = k[1];
      logic a = k[0];
      carry_in = ci; cell_in = {1'b1, 1'b0, b, a};
      @(negedge clk);
      chk("R10 sum", cell_out, a ^ b ^ ci);
      chk("R10 carry", carry_out, (a & b) | (ci & (a ^ b)));
    end
    carry_in = 0; cell_in = 4'h0; ram_we = 1; ram_din = 1;
    @(negedge clk); ram_we = 0; ram_din = 0;
    @(negedge clk);
    chk("R11 we ignored", cell_out, 0);
  endtask

  task automatic t_ram;
    logic [19:0] c = 20'h80000;
    load_ctx(c);
    chk("R2 top bit", scan_out, 1);
    cell_in = 4'h0;
    do_reconf(1'b0);
    cell_in = 4'h5; @(negedge clk);
    chk("R11 empty", cell_out, 0);
    ram_we = 1; ram_din = 1; @(negedge clk);
    ram_we = 0; ram_din = 0; @(negedge clk);
    chk("R11 written", cell_out, 1);
    cell_in = 4'h4; @(negedge clk);
    chk("R11 other addr", cell_out, 0);
    cell_in = 4'h5;
    do_reconf(1'b1);
    chk("R11 reload clears", cell_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_and_comb();
    t_reg();
    t_carry();
    t_ram();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule